// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the status flags of a UART core and turns them into one interrupt request. The shift and baud logic send it single-cycle event pulses. These pulses report a byte received, the transmit buffer handed to the shifter, a frame finished, an idle line, an overrun, noise, a framing error, a parity error, a detected line break, and the stop bit of a sent break character. The register decoder sends it single-cycle access strobes for the status register, the data register, the line-break control register and the send-break request. The block holds each flag until the access sequence that belongs to that flag removes it. No flag is write-one-to-clear.

The block has no streaming interface. Every input is a plain strobe or level that is sampled on each clock, so there is no back-pressure. The status byte, the line-break flag, the send-break request and the interrupt are plain registered outputs. The status byte has this bit layout: bit 7 transmit-empty, bit 6 transmit-complete, bit 5 receive-full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing error, bit 0 parity error.

A two-step sequence, such as a status read followed by a data read, is tracked by an armed bit. A status read sets the armed bit. Any other register access clears it. The decoder issues at most one access strobe per cycle.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, `status` is 0xC0 (bits 7 and 6 set, all others clear), and `lb_flag`, `sbk_req` and `irq` are 0.
- R2: Each event pulse sets its flag, which is visible on the outputs after the next clock edge. The status bit positions are: ev_tx_load to bit 7, ev_frame_done to bit 6, ev_rx_byte to bit 5, ev_idle to bit 4, ev_overrun to bit 3, ev_noise to bit 2, ev_frame_err to bit 1, ev_parity_err to bit 0. If an event and a clear of the same flag occur in the same cycle, the flag stays set.
- R3: The error and idle flags (bits 4 to 0) clear only on `rd_data` when a `rd_stat` came before it with no other access in between. A `rd_data` with no `rd_stat` before it leaves them unchanged. An intervening `wr_lb`, `wr_stat`, `wr_data` or `wr_sbk` cancels the sequence.
- R4: Receive-full (bit 5) clears on any `rd_data`, whether or not a `rd_stat` came first. It also clears on `wr_stat` with `wdata[5]`=0. A `wr_stat` has no effect on any other status bit, and none on bit 5 when `wdata[5]`=1.
- R5: Transmit-complete (bit 6) clears on `wr_data` only when a `rd_stat` came before it with no other access in between. A `wr_data` without that `rd_stat` leaves it set.
- R6: Transmit-empty (bit 7) clears on every `wr_data`, with no sequence needed.
- R7: `ev_line_break` sets `lb_flag`. The flag clears on `wr_lb` with `wdata[0]`=0. A `wr_lb` with `wdata[0]`=1 leaves it unchanged.
- R8: `wr_sbk` sets `sbk_req`. `ev_break_stop` clears it, unless `wr_sbk` occurs in the same cycle.
- R9: `irq` is a register. It is high in the cycle after any of the following holds: bit 7 and `en_txe`; bit 6 and `en_tc`; (bit 5 or bit 3) and `en_rx`; bit 4 and `en_idle`; bit 0 and `en_pe`; `lb_flag` and `en_lb`. The noise and framing-error flags never raise `irq`.
- R10: Repeated `rd_stat` strobes keep the sequence armed. The completing access uses up the armed state, so a later `rd_data` without a new `rd_stat` does not clear the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_byte | input | 1 | Received byte moved to the receive buffer |
| ev_tx_load | input | 1 | Transmit buffer handed to the shifter |
| ev_frame_done | input | 1 | Last frame finished shifting out |
| ev_idle | input | 1 | Idle line seen |
| ev_overrun | input | 1 | Byte lost to overrun |
| ev_noise | input | 1 | Noise seen on a frame |
| ev_frame_err | input | 1 | Stop bit missing |
| ev_parity_err | input | 1 | Parity mismatch |
| ev_line_break | input | 1 | Line break detected |
| ev_break_stop | input | 1 | Stop bit of the sent break character |
| rd_stat | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| wr_data | input | 1 | Data register write strobe |
| wr_stat | input | 1 | Status register write strobe |
| wr_lb | input | 1 | Line-break control register write strobe |
| wr_sbk | input | 1 | Send-break request strobe |
| wdata | input | 8 | Write data used by `wr_stat` and `wr_lb` |
| en_txe | input | 1 | Interrupt enable for transmit-empty |
| en_tc | input | 1 | Interrupt enable for transmit-complete |
| en_rx | input | 1 | Interrupt enable for receive-full and overrun |
| en_idle | input | 1 | Interrupt enable for idle |
| en_pe | input | 1 | Interrupt enable for parity error |
| en_lb | input | 1 | Interrupt enable for line break |
| status | output | 8 | Status flags |
| lb_flag | output | 1 | Line-break flag |
| sbk_req | output | 1 | Send-break request |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after the armed-sequence corner cases first. It checks a data read without a status read first, a control write between the two steps, repeated status reads, and a second data read after the armed state is used up. A design that got any of these wrong would either drop error flags too early or fail to clear them. The bench also checks the split between the clearing rules of the transmit-empty and transmit-complete bits. A design that cleared transmit-complete on a plain data write would lose frame-end interrupts. The bench also drives status writes with mixed bit values to show that only bit 5 responds. The remaining checks cover event-over-clear priority in the same cycle, which a wrong design would break by losing a fresh error. They also cover the interrupt mask, which a wrong design would break if noise or framing errors reached `irq`.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  // Status byte width and bit positions (software decodes these).
  localparam int STAT_W  = 8;
  localparam int DATA_W  = 8;
  localparam int TXE_B   = 7;
  localparam int TC_B    = 6;
  localparam int RXNE_B  = 5;
  localparam int IDLE_B  = 4;
  localparam int OVR_B   = 3;
  localparam int NOISE_B = 2;
  localparam int FERR_B  = 1;
  localparam int PERR_B  = 0;
  // Flags cleared by status read followed by data read.
  localparam int ERR_TOP = IDLE_B;
  // Reset image: transmit side starts empty and complete.
  localparam logic [STAT_W-1:0] STAT_RST =
    STAT_W'((1 << TXE_B) | (1 << TC_B));
  // Write data bit that clears the line-break flag when zero.
  localparam int LB_WBIT = 0;
endpackage

// File: rtl/flag_cell.sv
module flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // Event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/arm_tracker.sv
module arm_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd_i,
  input  logic other_acc_i,
  output logic armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            armed_o <= 1'b0;
    else if (stat_rd_i)    armed_o <= 1'b1;
    else if (other_acc_i)  armed_o <= 1'b0;
  end

  // R10
  arm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |=> armed_o);
  // R3
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (other_acc_i && !stat_rd_i) |=> !armed_o);
endmodule

// File: rtl/status_bank.sv
module status_bank
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec_i,
  input  logic [STAT_W-1:0] clr_vec_i,
  output logic [STAT_W-1:0] flags_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    flag_cell #(.RST_VAL(STAT_RST[b])) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec_i[b]),
      .clr_i (clr_vec_i[b]),
      .q_o   (flags_o[b])
    );
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] flags_i,
  input  logic              lb_i,
  input  logic              en_txe_i,
  input  logic              en_tc_i,
  input  logic              en_rx_i,
  input  logic              en_idle_i,
  input  logic              en_pe_i,
  input  logic              en_lb_i,
  output logic              irq_o
);
  logic pending;
  logic flags_unused;

  // Noise and framing error have no enable of their own.
  assign flags_unused = flags_i[NOISE_B] ^ flags_i[FERR_B];

  always_comb begin
    pending = (flags_i[TXE_B]  & en_txe_i)
            | (flags_i[TC_B]   & en_tc_i)
            | ((flags_i[RXNE_B] | flags_i[OVR_B]) & en_rx_i)
            | (flags_i[IDLE_B] & en_idle_i)
            | (flags_i[PERR_B] & en_pe_i)
            | (lb_i            & en_lb_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending;
  end

  // R9
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_txe_i && !en_tc_i && !en_rx_i && !en_idle_i && !en_pe_i && !en_lb_i)
      |=> !irq_o);
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_byte,
  input  logic              ev_tx_load,
  input  logic              ev_frame_done,
  input  logic              ev_idle,
  input  logic              ev_overrun,
  input  logic              ev_noise,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_line_break,
  input  logic              ev_break_stop,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              wr_data,
  input  logic              wr_stat,
  input  logic              wr_lb,
  input  logic              wr_sbk,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en_txe,
  input  logic              en_tc,
  input  logic              en_rx,
  input  logic              en_idle,
  input  logic              en_pe,
  input  logic              en_lb,
  output logic [STAT_W-1:0] status,
  output logic              lb_flag,
  output logic              sbk_req,
  output logic              irq
);
  logic              armed;
  logic              other_acc;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [DATA_W-1:0] wdata_unused;

  assign wdata_unused = wdata & ~(DATA_W'(1 << RXNE_B) | DATA_W'(1 << LB_WBIT));

  // Any access other than a status read breaks a pending sequence.
  assign other_acc = rd_data | wr_data | wr_stat | wr_lb | wr_sbk;

  arm_tracker u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_rd_i   (rd_stat),
    .other_acc_i (other_acc),
    .armed_o     (armed)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[TXE_B]   = ev_tx_load;
    set_vec[TC_B]    = ev_frame_done;
    set_vec[RXNE_B]  = ev_rx_byte;
    set_vec[IDLE_B]  = ev_idle;
    set_vec[OVR_B]   = ev_overrun;
    set_vec[NOISE_B] = ev_noise;
    set_vec[FERR_B]  = ev_frame_err;
    set_vec[PERR_B]  = ev_parity_err;
  end

  always_comb begin
    clr_vec         = '0;
    clr_vec[TXE_B]  = wr_data;
    clr_vec[TC_B]   = armed & wr_data;
    clr_vec[RXNE_B] = rd_data | (wr_stat & ~wdata[RXNE_B]);
    for (int b = 0; b <= ERR_TOP; b++) begin
      clr_vec[b] = armed & rd_data;
    end
  end

  status_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec_i (set_vec),
    .clr_vec_i (clr_vec),
    .flags_o   (status)
  );

  flag_cell #(.RST_VAL(1'b0)) u_lb (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_line_break),
    .clr_i (wr_lb & ~wdata[LB_WBIT]),
    .q_o   (lb_flag)
  );

  flag_cell #(.RST_VAL(1'b0)) u_sbk (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_sbk),
    .clr_i (ev_break_stop),
    .q_o   (sbk_req)
  );

  irq_merge u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_i   (status),
    .lb_i      (lb_flag),
    .en_txe_i  (en_txe),
    .en_tc_i   (en_tc),
    .en_rx_i   (en_rx),
    .en_idle_i (en_idle),
    .en_pe_i   (en_pe),
    .en_lb_i   (en_lb),
    .irq_o     (irq)
  );

  // R6
  txe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ev_tx_load) |=> !status[TXE_B]);
  // R5
  tc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !armed && !ev_frame_done && status[TC_B]) |=> status[TC_B]);
  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ev_idle && !ev_overrun && !ev_noise && !ev_frame_err && !ev_parity_err)
      |=> (status[ERR_TOP:0] == $past(status[ERR_TOP:0])) || !$past(rst_n));
  // R8
  sbk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_break_stop && !wr_sbk) |=> !sbk_req);
  // R7
  lb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_line_break |=> lb_flag);
endmodule

// File: tb/test_uart_flag_ctrl.sv
module test_uart_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic rd_stat = 0, rd_data = 0, wr_data = 0, wr_stat = 0, wr_lb = 0, wr_sbk = 0;
  logic [7:0] wdata = '0;
  logic en_txe = 0, en_tc = 0, en_rx = 0, en_idle = 0, en_pe = 0, en_lb = 0;
  logic [7:0] status;
  logic lb_flag, sbk_req, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_flag_ctrl i_uart_flag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_byte(ev[5]), .ev_tx_load(ev[7]), .ev_frame_done(ev[6]),
    .ev_idle(ev[4]), .ev_overrun(ev[3]), .ev_noise(ev[2]),
    .ev_frame_err(ev[1]), .ev_parity_err(ev[0]),
    .ev_line_break(ev[8]), .ev_break_stop(ev[9]),
    .rd_stat(rd_stat), .rd_data(rd_data), .wr_data(wr_data),
    .wr_stat(wr_stat), .wr_lb(wr_lb), .wr_sbk(wr_sbk), .wdata(wdata),
    .en_txe(en_txe), .en_tc(en_tc), .en_rx(en_rx), .en_idle(en_idle),
    .en_pe(en_pe), .en_lb(en_lb),
    .status(status), .lb_flag(lb_flag), .sbk_req(sbk_req), .irq(irq)
  );

  // Vector: req[38:35] ev[34:25] op[24:22] wdata[21:14] stat[13:6] lb[5] sbk[4] pad[3:0]
  // op: 0 none, 1 rd_stat, 2 rd_data, 3 wr_data, 4 wr_stat, 5 wr_lb, 6 wr_sbk
  localparam int NV = 28;
  localparam logic [38:0] VEC [NV] = '{
    {4'd2,  10'h020, 3'd0, 8'h00, 8'hE0, 1'b0, 1'b0, 4'h0}, // R2 rx byte
    {4'd2,  10'h01F, 3'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 4'h0}, // R2 errors+idle
    {4'd4,  10'h000, 3'd2, 8'h00, 8'hDF, 1'b0, 1'b0, 4'h0}, // R4 unarmed read
    {4'd3,  10'h000, 3'd1, 8'h00, 8'hDF, 1'b0, 1'b0, 4'h0}, // R3 arm
    {4'd3,  10'h000, 3'd5, 8'h01, 8'hDF, 1'b0, 1'b0, 4'h0}, // R3 disarm by wr_lb
    {4'd3,  10'h000, 3'd2, 8'h00, 8'hDF, 1'b0, 1'b0, 4'h0}, // R3 not cleared
    {4'd10, 10'h000, 3'd1, 8'h00, 8'hDF, 1'b0, 1'b0, 4'h0}, // R10 arm
    {4'd10, 10'h000, 3'd1, 8'h00, 8'hDF, 1'b0, 1'b0, 4'h0}, // R10 re-arm
    {4'd3,  10'h000, 3'd2, 8'h00, 8'hC0, 1'b0, 1'b0, 4'h0}, // R3 cleared
    {4'd2,  10'h001, 3'd0, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R2 parity
    {4'd10, 10'h000, 3'd2, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R10 used up
    {4'd6,  10'h000, 3'd3, 8'h00, 8'h41, 1'b0, 1'b0, 4'h0}, // R6 txe clears, tc stays
    {4'd5,  10'h000, 3'd1, 8'h00, 8'h41, 1'b0, 1'b0, 4'h0}, // R5 arm
    {4'd5,  10'h000, 3'd3, 8'h00, 8'h01, 1'b0, 1'b0, 4'h0}, // R5 tc clears
    {4'd2,  10'h020, 3'd0, 8'h00, 8'h21, 1'b0, 1'b0, 4'h0}, // R2 rx byte
    {4'd4,  10'h000, 3'd4, 8'h20, 8'h21, 1'b0, 1'b0, 4'h0}, // R4 write 1 keeps
    {4'd4,  10'h000, 3'd4, 8'h00, 8'h01, 1'b0, 1'b0, 4'h0}, // R4 write 0 clears only bit5
    {4'd2,  10'h0C0, 3'd0, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R2 tx events
    {4'd7,  10'h100, 3'd0, 8'h00, 8'hC1, 1'b1, 1'b0, 4'h0}, // R7 set
    {4'd7,  10'h000, 3'd5, 8'h01, 8'hC1, 1'b1, 1'b0, 4'h0}, // R7 write 1 keeps
    {4'd7,  10'h000, 3'd5, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R7 write 0 clears
    {4'd8,  10'h000, 3'd6, 8'h00, 8'hC1, 1'b0, 1'b1, 4'h0}, // R8 request
    {4'd8,  10'h200, 3'd0, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R8 self clear
    {4'd2,  10'h000, 3'd1, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R2 arm
    {4'd2,  10'h001, 3'd2, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R2 set beats clear
    {4'd3,  10'h000, 3'd1, 8'h00, 8'hC1, 1'b0, 1'b0, 4'h0}, // R3 arm
    {4'd3,  10'h000, 3'd2, 8'h00, 8'hC0, 1'b0, 1'b0, 4'h0}, // R3 clear
    {4'd2,  10'h080, 3'd3, 8'h00, 8'hC0, 1'b0, 1'b0, 4'h0}  // R2 txe set beats write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [9:0] e, input logic [2:0] op, input logic [7:0] wd);
    @(negedge clk);
    ev = e; wdata = wd;
    rd_stat = (op == 3'd1); rd_data = (op == 3'd2); wr_data = (op == 3'd3);
    wr_stat = (op == 3'd4); wr_lb = (op == 3'd5); wr_sbk = (op == 3'd6);
    @(negedge clk);
    ev = '0; wdata = '0;
    rd_stat = 0; rd_data = 0; wr_data = 0; wr_stat = 0; wr_lb = 0; wr_sbk = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(status), 32'hC0);
    chk("R1 lb_flag", 32'(lb_flag), 0);
    chk("R1 sbk_req", 32'(sbk_req), 0);
    chk("R1 irq", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      apply(v[34:25], v[24:22], v[21:14]);
      chk($sformatf("R%0d vec %0d status", v[38:35], i), 32'(status), 32'(v[13:6]));
      chk($sformatf("R%0d vec %0d lb", v[38:35], i), 32'(lb_flag), 32'(v[5]));
      chk($sformatf("R%0d vec %0d sbk", v[38:35], i), 32'(sbk_req), 32'(v[4]));
    end

    // R9 interrupt mask, state now 0xC0
    @(negedge clk); en_txe = 1;
    @(negedge clk); chk("R9 txe enabled", 32'(irq), 1);
    en_txe = 0; en_rx = 1;
    @(negedge clk); chk("R9 rx enabled, no rx flags", 32'(irq), 0);
    apply(10'h008, 3'd0, 8'h00);
    @(negedge clk); chk("R9 overrun via rx enable", 32'(irq), 1);
    apply(10'h000, 3'd1, 8'h00);
    apply(10'h000, 3'd2, 8'h00);
    @(negedge clk); chk("R9 overrun cleared", 32'(irq), 0);
    en_idle = 1; en_pe = 1; en_lb = 1;
    apply(10'h006, 3'd0, 8'h00);
    @(negedge clk);
    chk("R9 noise/framing set", 32'(status), 32'hC6);
    chk("R9 noise/framing no irq", 32'(irq), 0);
    apply(10'h100, 3'd0, 8'h00);
    @(negedge clk); chk("R9 line break irq", 32'(irq), 1);
    finish_run();
  end
endmodule